// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the timing core of a dual-slope integrating analog-to-digital converter. The switches, integrator and comparator are outside the digital design. The block takes a fast clock and divides it by four to make a count clock. It steps an external front end through three phases: auto-zero, a fixed-length signal integrate, and reference de-integrate. It reads a comparator through a synchronizer. The comparator level at the end of integration gives the input polarity and sets the direction of the reference. A change of that level during de-integration ends the measurement.

The count reached during de-integration is the reading. It is kept directly in four cascaded decimal digits, so no conversion step is needed. A conversion cycle always lasts 4000 counts, because auto-zero absorbs whatever time de-integration did not use. Once per cycle the block presents a latched reading, a sign and an overrange flag to a display stage, and marks the update with a one-clock strobe.

The state machine has three states:
- `PH_AUTOZERO` moves to `PH_INTEGRATE` when the cycle count wraps.
- `PH_INTEGRATE` moves to `PH_DEINTEGRATE` after 1000 counts.
- `PH_DEINTEGRATE` moves to `PH_AUTOZERO` on a comparator crossing, or on reaching 2000 counts.

Top module: `dsq_sequencer`

## Requirements
- R1: The count clock is the input clock divided by four, and one full conversion cycle is 4000 counts, so `int_en` rises once every 16000 clock cycles whatever the reading.
- R2: The integrate phase (`int_en` high) lasts exactly 1000 counts, that is 4000 clock cycles.
- R3: Exactly one of `az_en`, `int_en`, `deint_en` is high at any time. The order is always auto-zero, then integrate, then de-integrate, then auto-zero again.
- R4: `comp_in` passes through a two-register synchronizer. A crossing is the synchronized comparator differing from its level at the end of integration. The reading is the number of de-integrate counts completed before the crossing is seen, from 0 to 1999. It is given in decimal digits on `rdg_bcd`: units in bits 3:0, tens in bits 7:4, hundreds in bits 11:8 and thousands in bits 15:12.
- R5: If the synchronized comparator is low at the end of integration, the input is negative: `rdg_neg` is latched as 1 and `ref_neg` stays low during de-integration. If it is high, `rdg_neg` is latched as 0 and `ref_neg` is high for the whole de-integrate phase. `ref_neg` is never high outside de-integration.
- R6: If no crossing is seen within 2000 counts, de-integration ends, `rdg_ovr` is latched as 1 and the reading is 2000 (`16'h2000`). A crossing seen at count 1999 gives reading 1999 with `rdg_ovr` 0.
- R7: `rdg_vld` is a single-clock pulse issued once per conversion, after de-integration ends. `rdg_bcd`, `rdg_neg` and `rdg_ovr` change only together with that pulse.
- R8: A synchronous reset puts the sequencer into auto-zero with the counters and all latched outputs cleared. The first auto-zero after reset lasts 1000 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| comp_in | input | 1 | Asynchronous comparator output from the front end |
| az_en | output | 1 | Auto-zero phase select |
| int_en | output | 1 | Signal integrate phase select |
| deint_en | output | 1 | Reference de-integrate phase select |
| ref_neg | output | 1 | Reference applied in the inverted direction (input was positive) |
| rdg_bcd | output | 16 | Latched reading, four decimal digits |
| rdg_neg | output | 1 | Latched sign, 1 for a negative input |
| rdg_ovr | output | 1 | Latched overrange flag |
| rdg_vld | output | 1 | One-clock strobe marking a new latched result |

## Verification
Two cases are the hardest to reach from the ports. The first is the edge between a reading of 1999 and an overrange. The second is a crossing on the very first de-integrate count. Both depend on exactly when a comparator change passes through the synchronizer and meets the divided count clock. The bench models the comparator by counting clock cycles from the rise of `deint_en` and flipping it 4n+1 cycles later, so that the synchronized change lands on the tick that finishes count n. Directed runs cover n of 0 and 1999 and a conversion with no flip at all. Seeded random polarities and counts, some above full scale, cover the rest.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [1:0] {
        PH_AUTOZERO    = 2'd0,
        PH_INTEGRATE   = 2'd1,
        PH_DEINTEGRATE = 2'd2
    } phase_e;

    // Packs a binary value into up to eight decimal digits, units lowest.
    function automatic logic [31:0] bin2bcd(input int unsigned val);
        logic [31:0] r;
        int unsigned v;
        r = '0;
        v = val;
        for (int i = 0; i < 8; i++) begin
            r[i*4 +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/dsq_prescaler.sv
module dsq_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    // R1: count-clock ticks are never back to back when dividing
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (DIV > 1 && tick) |=> !tick);

endmodule

// File: rtl/dsq_bcd_count.sv
module dsq_bcd_count #(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  inc,
    output logic [DIGITS*4-1:0]   value
);
    logic [DIGITS-1:0] carry;

    assign carry[0] = inc;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] d_q;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                d_q <= '0;
            end else if (carry[g]) begin
                d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
            end
        end

        if (g < DIGITS - 1) begin : g_carry
            assign carry[g+1] = carry[g] && (d_q == 4'd9);
        end

        assign value[g*4 +: 4] = d_q;

        // R4: every digit stays a decimal digit
        a_r4_digit_range: assert property (@(posedge clk) disable iff (rst)
            d_q <= 4'd9);
    end

endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer #(
    parameter int CLK_DIV      = 4,
    parameter int INT_COUNTS   = 1000,
    parameter int DEINT_MAX    = 2000,
    parameter int CYCLE_COUNTS = 4000,
    parameter int DIGITS       = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 comp_in,
    output logic                 az_en,
    output logic                 int_en,
    output logic                 deint_en,
    output logic                 ref_neg,
    output logic [DIGITS*4-1:0]  rdg_bcd,
    output logic                 rdg_neg,
    output logic                 rdg_ovr,
    output logic                 rdg_vld
);
    import dsq_pkg::*;

    localparam int CW = $clog2(CYCLE_COUNTS);
    localparam int BW = DIGITS * 4;
    localparam logic [CW-1:0] CYC_LAST = CW'(CYCLE_COUNTS - 1);
    localparam logic [CW-1:0] INT_LAST = CW'(INT_COUNTS - 1);
    localparam logic [CW-1:0] CYC_INIT = CW'(INT_COUNTS + DEINT_MAX);
    localparam logic [31:0]   LAST_W   = bin2bcd(DEINT_MAX - 1);
    localparam logic [31:0]   FULL_W   = bin2bcd(DEINT_MAX);
    localparam logic [BW-1:0] LAST_RDG = LAST_W[BW-1:0];
    localparam logic [BW-1:0] FULL_RDG = FULL_W[BW-1:0];

    phase_e          state_q, state_d;
    logic            tick;
    logic            comp_s1, comp_s2;
    logic [CW-1:0]   cyc_q;
    logic            pol_q;
    logic            fin_q;
    logic [BW-1:0]   count;
    logic            crossed, at_last, int_done, deint_done;
    logic            cnt_clr, cnt_inc;

    dsq_prescaler #(.DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dsq_bcd_count #(.DIGITS(DIGITS)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .value (count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            comp_s1 <= 1'b0;
            comp_s2 <= 1'b0;
        end else begin
            comp_s1 <= comp_in;
            comp_s2 <= comp_s1;
        end
    end

    assign crossed    = (comp_s2 != pol_q);
    assign at_last    = (count == LAST_RDG);
    assign int_done   = tick && (state_q == PH_INTEGRATE) && (cyc_q == INT_LAST);
    assign deint_done = tick && (state_q == PH_DEINTEGRATE) && (crossed || at_last);
    assign cnt_clr    = int_done;
    assign cnt_inc    = tick && (state_q == PH_DEINTEGRATE) && !crossed;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_AUTOZERO;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_AUTOZERO:    if (tick && cyc_q == CYC_LAST) state_d = PH_INTEGRATE;
            PH_INTEGRATE:   if (int_done)                  state_d = PH_DEINTEGRATE;
            PH_DEINTEGRATE: if (deint_done)                state_d = PH_AUTOZERO;
            default:                                       state_d = PH_AUTOZERO;
        endcase
    end

    // Phase-select outputs
    always_comb begin
        az_en    = 1'b0;
        int_en   = 1'b0;
        deint_en = 1'b0;
        unique case (state_q)
            PH_AUTOZERO:    az_en    = 1'b1;
            PH_INTEGRATE:   int_en   = 1'b1;
            PH_DEINTEGRATE: deint_en = 1'b1;
            default:        az_en    = 1'b1;
        endcase
        ref_neg = deint_en && pol_q;
    end

    // Cycle count, polarity capture and result latch
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q   <= CYC_INIT;
            pol_q   <= 1'b0;
            fin_q   <= 1'b0;
            rdg_bcd <= '0;
            rdg_neg <= 1'b0;
            rdg_ovr <= 1'b0;
            rdg_vld <= 1'b0;
        end else begin
            if (tick) begin
                cyc_q <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
            end
            if (int_done) begin
                pol_q <= comp_s2;
            end
            fin_q   <= deint_done;
            rdg_vld <= fin_q;
            if (fin_q) begin
                rdg_bcd <= count;
                rdg_neg <= !pol_q;
                rdg_ovr <= (count == FULL_RDG);
            end
        end
    end

    // R3: one phase at a time, fixed order
    a_r3_one_phase: assert property (@(posedge clk) disable iff (rst)
        $countones({az_en, int_en, deint_en}) == 1);
    a_r3_int_to_deint: assert property (@(posedge clk) disable iff (rst)
        $fell(int_en) |-> deint_en);
    a_r3_deint_to_az: assert property (@(posedge clk) disable iff (rst)
        $fell(deint_en) |-> az_en);
    // R5: reference direction only meaningful in de-integrate
    a_r5_ref_in_deint: assert property (@(posedge clk) disable iff (rst)
        ref_neg |-> deint_en);
    // R7: strobe is a single clock and results hold between strobes
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
        rdg_vld |=> !rdg_vld);
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !rdg_vld |-> ($stable(rdg_bcd) && $stable(rdg_neg) && $stable(rdg_ovr)));
    // R6: an overrange result always carries the full-scale reading
    a_r6_ovr_full: assert property (@(posedge clk) disable iff (rst)
        (rdg_vld && rdg_ovr) |-> rdg_bcd == FULL_RDG);

endmodule

// File: tb/sim_dsq_sequencer.sv
module sim_dsq_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        comp_in = 1'b1;
    logic        az_en, int_en, deint_en, ref_neg;
    logic [15:0] rdg_bcd;
    logic        rdg_neg, rdg_ovr, rdg_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dsq_sequencer u0 (
        .clk      (clk),
        .rst      (rst),
        .comp_in  (comp_in),
        .az_en    (az_en),
        .int_en   (int_en),
        .deint_en (deint_en),
        .ref_neg  (ref_neg),
        .rdg_bcd  (rdg_bcd),
        .rdg_neg  (rdg_neg),
        .rdg_ovr  (rdg_ovr),
        .rdg_vld  (rdg_vld)
    );

    function automatic logic [15:0] to_digits(input int unsigned v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1 and R2 monitors: integrate length and cycle period
    int int_len = 0;
    int since_rise = 0;
    bit seen_rise = 1'b0;
    logic int_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            since_rise++;
            if (int_en && !int_prev) begin
                if (seen_rise) check("R1 cycle period", since_rise, 16000);
                seen_rise = 1'b1;
                since_rise = 0;
            end
            if (int_en) int_len++;
            else if (int_len > 0) begin
                check("R2 integrate length", int_len, 4000);
                int_len = 0;
            end
            int_prev = int_en;
        end
    end

    task automatic convert(input bit pol, input int unsigned n);
        int unsigned exp_rdg;
        comp_in = pol;
        do @(negedge clk); while (!deint_en);
        check("R3 order az", az_en, 0);
        check("R3 order int", int_en, 0);
        check("R5 ref direction", ref_neg, pol);
        if (n < 2000) begin
            repeat (4 * n + 1) @(posedge clk);
            @(negedge clk);
            comp_in = ~pol;
        end
        do @(negedge clk); while (!rdg_vld);
        exp_rdg = (n >= 2000) ? 2000 : n;
        check("R4 reading", rdg_bcd, to_digits(exp_rdg));
        check("R5 sign", rdg_neg, !pol);
        check("R6 overrange", rdg_ovr, n >= 2000);
        check("R3 back in auto-zero", az_en, 1);
        @(negedge clk);
        check("R7 strobe single", rdg_vld, 0);
        check("R7 hold", rdg_bcd, to_digits(exp_rdg));
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check("R8 reset az", az_en, 1);
        check("R8 reset int", int_en, 0);
        check("R8 reset deint", deint_en, 0);
        check("R8 reset strobe", rdg_vld, 0);
        check("R8 reset reading", {rdg_bcd, rdg_neg, rdg_ovr}, 0);
        rst = 1'b0;
        convert(1'b1, 0);      // R4 crossing on first count
        convert(1'b0, 1999);   // R6 last count below full scale
        convert(1'b1, 2500);   // R6 no crossing
        convert(1'b0, 1000);
        for (int i = 0; i < 5; i++) begin
            convert(1'($urandom % 2), $urandom_range(0, 2100));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule